// File: doc/BRIEF.md
# Next Program Counter Unit

This block works out where a 32-bit RISC core fetches its next instruction. Each cycle it takes the current instruction address, the instruction word fetched from that address, a flag that says whether the two source registers hold the same value, and the value of the first source register. It decodes the instruction and picks one of four addresses:

- the sequential address, which is the current address plus 4;
- a PC-relative branch target;
- a region-relative jump target;
- a register-supplied target.

For the call instruction it also supplies the return address, with a write enable aimed at the link register.

The results are registered. The address, the redirect flag, the link value and the link enable all show up one clock after the inputs that produced them. The fetch stage can load the new address straight from these outputs. The register file can write the link value into register 31 when the enable is high. Fetch, register reads and hazard handling live outside this block.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `next_pc` holds the parameter `RESET_PC` (default 0), and `redirect`, `link_we` and `link_addr` are all zero.
- R2: The opcode is `instr[31:26]`. Any opcode other than 2, 3, 4 or 5, and opcode 0 with any function code other than 8, gives `next_pc = pc + 4` and `redirect = 0`.
- R3: Opcode 4 (branch on equal) is taken when `regs_equal` is 1. Its target is `pc + 4` plus the sign-extended `instr[15:0]` times 4. When `regs_equal` is 0 it falls through to `pc + 4`.
- R4: Opcode 5 (branch on not equal) is taken when `regs_equal` is 0. Its target is formed the same way as in R3. When `regs_equal` is 1 it falls through to `pc + 4`.
- R5: A branch offset with bit 15 set moves the target backwards. The most negative offset, 0x8000, lands 131068 bytes below `pc`.
- R6: Opcode 2 (jump) gives `next_pc = {(pc+4)[31:28], instr[25:0], 2'b00}` with `redirect = 1`.
- R7: Opcode 3 (jump and link) goes to the same target as R6. It also sets `link_we = 1` with `link_addr = pc + 4`.
- R8: Opcode 0 with function code `instr[5:0] = 8` (jump register) gives `next_pc = rs_value` with `redirect = 1`. The value is used unchanged, with no alignment applied.
- R9: `link_we` is 1 only for opcode 3. Outside reset, `link_addr` always carries `pc + 4` of the previous cycle.
- R10: `redirect` is 1 exactly when `next_pc` comes from a taken branch or a jump. All outputs reflect the inputs sampled at the preceding rising edge.
- R11: The upper four bits of a jump target come from `pc + 4`. When `pc + 4` crosses into a new 256 MB region, the target lands in that new region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | 32 | Address of the current instruction |
| instr | input | 32 | Instruction word at `pc` |
| regs_equal | input | 1 | 1 when the two source registers compare equal |
| rs_value | input | 32 | First source register value, used by jump register |
| next_pc | output | 32 | Registered next fetch address |
| redirect | output | 1 | Registered flag: `next_pc` is not the sequential address |
| link_addr | output | 32 | Registered return address (`pc + 4`) |
| link_we | output | 1 | Registered write enable for register 31 |

## Verification
The assertions assume that `pc` is word aligned. On that basis, the branch and jump targets relate to `pc` only through `pc + 4`, and the sequential address never wraps in an unexpected way. They make no assumption about `rs_value`, because jump register passes it through as is. The stimulus keeps to aligned addresses by clearing the low two bits of every `pc` it drives, including the random ones. It lets `rs_value` and `regs_equal` take any value.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int ADDR_W = 32;
  localparam int OFF_W  = 16;
  localparam int IDX_W  = 26;
  localparam int REG_W  = ADDR_W - 2 - IDX_W;

  localparam logic [5:0] OPC_SPECIAL = 6'd0;
  localparam logic [5:0] OPC_JUMP    = 6'd2;
  localparam logic [5:0] OPC_CALL    = 6'd3;
  localparam logic [5:0] OPC_BREQ    = 6'd4;
  localparam logic [5:0] OPC_BRNE    = 6'd5;
  localparam logic [5:0] FN_JREG     = 6'd8;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BREQ,
    FLOW_BRNE,
    FLOW_JUMP,
    FLOW_CALL,
    FLOW_JREG
  } flow_e;

  function automatic logic [ADDR_W-1:0] seq_addr(input logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(4);
  endfunction

  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] seq,
                                                   input logic [OFF_W-1:0]  off);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
    return seq + (ext << 2);
  endfunction

  function automatic logic [ADDR_W-1:0] region_target(input logic [ADDR_W-1:0] seq,
                                                      input logic [IDX_W-1:0]  idx);
    return {seq[ADDR_W-1 -: REG_W], idx, 2'b00};
  endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [ADDR_W-1:0] instr,
  output flow_e             kind,
  output logic [OFF_W-1:0]  off,
  output logic [IDX_W-1:0]  idx
);
  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[ADDR_W-1 -: 6];
  assign fn  = instr[5:0];
  assign off = instr[OFF_W-1:0];
  assign idx = instr[IDX_W-1:0];

  always_comb begin
    kind = FLOW_SEQ;
    case (opc)
      OPC_BREQ:    kind = FLOW_BREQ;
      OPC_BRNE:    kind = FLOW_BRNE;
      OPC_JUMP:    kind = FLOW_JUMP;
      OPC_CALL:    kind = FLOW_CALL;
      OPC_SPECIAL: if (fn == FN_JREG) kind = FLOW_JREG;
      default:     kind = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  off,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] seq,
  output logic [ADDR_W-1:0] br_tgt,
  output logic [ADDR_W-1:0] jmp_tgt
);
  assign seq     = seq_addr(pc);
  assign br_tgt  = rel_target(seq, off);
  assign jmp_tgt = region_target(seq, idx);
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  flow_e             kind,
  input  logic              regs_equal,
  input  logic [ADDR_W-1:0] seq,
  input  logic [ADDR_W-1:0] br_tgt,
  input  logic [ADDR_W-1:0] jmp_tgt,
  input  logic [ADDR_W-1:0] rs_value,
  output logic [ADDR_W-1:0] nxt,
  output logic              redir,
  output logic              lnk_we
);
  always_comb begin
    nxt    = seq;
    redir  = 1'b0;
    lnk_we = 1'b0;
    unique case (kind)
      FLOW_BREQ: if (regs_equal)  begin nxt = br_tgt; redir = 1'b1; end
      FLOW_BRNE: if (!regs_equal) begin nxt = br_tgt; redir = 1'b1; end
      FLOW_JUMP: begin nxt = jmp_tgt; redir = 1'b1; end
      FLOW_CALL: begin nxt = jmp_tgt; redir = 1'b1; lnk_we = 1'b1; end
      FLOW_JREG: begin nxt = rs_value; redir = 1'b1; end
      default:   begin nxt = seq; redir = 1'b0; end
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pc,
  input  logic [31:0] instr,
  input  logic        regs_equal,
  input  logic [31:0] rs_value,
  output logic [31:0] next_pc,
  output logic        redirect,
  output logic [31:0] link_addr,
  output logic        link_we
);
  flow_e             kind;
  logic [OFF_W-1:0]  off;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] seq, br_tgt, jmp_tgt, nxt;
  logic              redir, lnk_we;

  // named events for the checks below
  logic ev_is_jump, ev_is_jreg, ev_is_breq;
  assign ev_is_jump = (instr[31:26] == OPC_JUMP) || (instr[31:26] == OPC_CALL);
  assign ev_is_jreg = (instr[31:26] == OPC_SPECIAL) && (instr[5:0] == FN_JREG);
  assign ev_is_breq = (instr[31:26] == OPC_BREQ);

  npc_decode u_dec (.instr(instr), .kind(kind), .off(off), .idx(idx));

  npc_target u_tgt (.pc(pc), .off(off), .idx(idx),
                    .seq(seq), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt));

  npc_select u_sel (.kind(kind), .regs_equal(regs_equal), .seq(seq),
                    .br_tgt(br_tgt), .jmp_tgt(jmp_tgt), .rs_value(rs_value),
                    .nxt(nxt), .redir(redir), .lnk_we(lnk_we));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc   <= RESET_PC;
      redirect  <= 1'b0;
      link_addr <= '0;
      link_we   <= 1'b0;
    end else begin
      next_pc   <= nxt;
      redirect  <= redir;
      link_addr <= seq;
      link_we   <= lnk_we;
    end
  end

  AST_SEQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !redirect) |-> (next_pc == $past(pc) + 32'd4)); // R2
  AST_BREQ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ev_is_breq) && !$past(regs_equal)) |-> !redirect); // R3
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ev_is_jump)) |-> (redirect && next_pc[31:28] == $past(seq[31:28]))); // R11
  AST_JREG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ev_is_jreg)) |-> (next_pc == $past(rs_value))); // R8
  AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && link_we) |-> ($past(instr[31:26]) == OPC_CALL)); // R9
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && link_we) |-> (link_addr == $past(pc) + 32'd4 && redirect)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !$past(rst_n) |-> (!link_we && !redirect)); // R1
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pc, instr, rs_value;
  logic        regs_equal;
  logic [31:0] next_pc, link_addr;
  logic        redirect, link_we;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  npc_unit i_npc_unit (.clk(clk), .rst_n(rst_n), .pc(pc), .instr(instr),
    .regs_equal(regs_equal), .rs_value(rs_value), .next_pc(next_pc),
    .redirect(redirect), .link_addr(link_addr), .link_we(link_we));

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: integer arithmetic on the instruction fields
  task automatic model(input logic [31:0] p, input logic [31:0] w, input logic eq,
                       input logic [31:0] r, output logic [31:0] np,
                       output logic rd, output logic lw);
    int unsigned op, fn, after;
    int off;
    op = w / 67108864; fn = w % 64; after = p + 4;
    off = int'(w % 65536); if (off >= 32768) off -= 65536;
    np = after; rd = 0; lw = 0;
    if ((op == 4 && eq) || (op == 5 && !eq)) begin np = after + off * 4; rd = 1; end
    else if (op == 2 || op == 3) begin
      np = (after / 268435456) * 268435456 + (w % 67108864) * 4; rd = 1; lw = (op == 3);
    end else if (op == 0 && fn == 8) begin np = r; rd = 1; end
  endtask

  task automatic step(input string tag, input logic [31:0] p, input logic [31:0] w,
                      input logic eq, input logic [31:0] r);
    logic [31:0] enp; logic erd, elw;
    pc = p; instr = w; regs_equal = eq; rs_value = r;
    model(p, w, eq, r, enp, erd, elw);
    @(negedge clk);
    check(tag, "next_pc", next_pc, enp);
    check({tag, "/R10"}, "redirect", {31'd0, redirect}, {31'd0, erd});
    check({tag, "/R9"}, "link_we", {31'd0, link_we}, {31'd0, elw});
    check({tag, "/R9"}, "link_addr", link_addr, p + 32'd4);
  endtask

  function automatic logic [31:0] itype(input int op, input logic [15:0] imm);
    return {op[5:0], 10'd0, imm};
  endfunction

  initial begin
    rst_n = 0; pc = 32'h40; instr = 32'h0C00_0010; regs_equal = 1; rs_value = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    check("R1", "next_pc", next_pc, 32'h0);
    check("R1", "redirect", {31'd0, redirect}, 32'd0);
    check("R1", "link_we", {31'd0, link_we}, 32'd0);
    check("R1", "link_addr", link_addr, 32'd0);
    rst_n = 1;
    step("R2", 32'h0000_1000, 32'h0122_4020, 0, 32'h0);           // add
    step("R2", 32'h0000_1004, 32'h8D28_0000, 1, 32'h0);           // load
    step("R3", 32'h0000_2000, itype(4, 16'd3), 1, 32'h0);
    step("R3", 32'h0000_2000, itype(4, 16'd3), 0, 32'h0);
    step("R4", 32'h0000_3000, itype(5, 16'hFFFE), 0, 32'h0);
    step("R4", 32'h0000_3000, itype(5, 16'hFFFE), 1, 32'h0);
    step("R5", 32'h0010_0000, itype(4, 16'h8000), 1, 32'h0);     // 0xE0004
    step("R5", 32'h0000_0010, itype(5, 16'hFFFB), 0, 32'h0);     // back to 0x0
    step("R6", 32'h1234_5678 & ~32'h3, {6'd2, 26'h3FF_FFFF}, 0, 32'h0);
    step("R7", 32'hA000_0100, {6'd3, 26'h000_0040}, 1, 32'h0);
    step("R11", 32'h1FFF_FFFC, {6'd2, 26'h000_0004}, 0, 32'h0);  // -> 0x20000010
    step("R8", 32'h0000_4000, 32'h0220_0008, 0, 32'h1357_9BDF);
    step("R8", 32'h0000_4000, 32'h0220_0009, 1, 32'h1357_9BDF);  // funct 9 not decoded
    step("R2", 32'hFFFF_FFFC, 32'h0000_0000, 0, 32'h0);          // wraps to 0
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w; int pick;
      w = $urandom; pick = $urandom_range(0, 5);
      if (pick < 5) w[31:26] = 6'(pick + (pick == 1 ? 0 : 0));
      if (pick == 0) w[5:0] = ($urandom_range(0, 1) != 0) ? 6'd8 : w[5:0];
      step("R10", $urandom & 32'hFFFF_FFFC, w, 1'($urandom), $urandom);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog R10 actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule